// File: doc/BRIEF.md
# Programmable Reference Divider with Monitor and Prescaled Outputs

This block divides a reference oscillator down to the rate a phase comparator works at. The oscillator arrives as a one-cycle strobe, `osc_tick`, on the block clock, with one strobe for each rising edge of the oscillator. A 15-bit down-counter loads a programmed ratio and produces a one-cycle reference pulse once every ratio oscillator edges. A ratio of 1 makes every oscillator edge a reference pulse, so the counter is bypassed. Ratios that cannot be used (0, 2, 3 and 4) are forced to 5, and a flag reports that this happened. A monitor copy of the reference pulse, `fr_out`, stays low until a control bit enables it.

A second path, `refout_pulse`, gives a scaled copy of the oscillator edges: off, or one pulse every 1, 2, 4 or 8 edges. Reset selects one pulse every 8 edges. All configuration is captured by a single write strobe. A new ratio only takes effect when the counter next reloads, so a reference period is never cut short.

`osc_tick` is a plain strobe. The block accepts every strobe and applies no back-pressure. No valid/ready stream exists, because all pins are control or status pins.

Top module: `refclk_divider`

## Requirements
- R1: The divide counter moves only on cycles where `osc_tick` is 1. Cycles without a strobe leave the reference phase unchanged.
- R2: With a working ratio N, `ref_pulse` is 1 for exactly one clock, in the clock after every N-th strobe. After reset the first pulse follows the N-th strobe.
- R3: A working ratio of 1 bypasses the division: once it is in force, every strobe gives a `ref_pulse` in the next clock.
- R4: A write with `cfg_rdiv` of 0, 2, 3 or 4 stores the ratio 5 and sets `rdiv_clamped` to 1. A write of 1 or of 5 to 32767 stores that value unchanged and clears `rdiv_clamped`.
- R5: A ratio written in the middle of a period takes effect only when the counter reaches its reload. The period in progress finishes with the old ratio.
- R6: `fr_out` is 0 whenever the stored monitor-enable bit is 0. When the bit is 1, `fr_out` equals `ref_pulse` in every cycle.
- R7: `cfg_refsel` encodes the prescaler setting: 3'd1 gives one pulse on every strobe, 3'd2 every 2nd strobe, 3'd3 every 4th and 3'd4 every 8th. Each pulse appears in the clock after the strobe. The prescale phase counts strobes from reset, and the selection does not reset it. Reset selects 3'd4.
- R8: A `cfg_refsel` of 3'd0, or any code from 3'd5 to 3'd7, holds `refout_pulse` at 0.
- R9: After reset all outputs are 0, the ratio is 5, the monitor is disabled and `rdiv_clamped` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator rising edge |
| cfg_wr | input | 1 | Captures all configuration fields |
| cfg_rdiv | input | 15 | Divide ratio to store |
| cfg_fr_en | input | 1 | Monitor-output enable to store |
| cfg_refsel | input | 3 | Prescaler selection to store |
| ref_pulse | output | 1 | Reference pulse to the phase comparator |
| fr_out | output | 1 | Gated monitor copy of the reference pulse |
| refout_pulse | output | 1 | Prescaled oscillator pulse |
| rdiv_clamped | output | 1 | Last ratio write was illegal and was forced to 5 |

## Verification
The embedded assertions check on every cycle that:
- the stored ratio never holds an illegal value;
- the counter steps down by exactly one per strobe and reloads the stored ratio;
- every reference pulse follows a strobe;
- the monitor and prescaler outputs stay low while they are disabled.

Only the bench scenarios can show the following:
- the full period length under gapped strobes;
- the deferred ratio change;
- the bypass behaviour;
- the prescaler phase carried across selection changes.

The bench shows these by comparing against a scoreboard model that runs on every strobe.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned RDIV_W = 15;
  localparam int unsigned PS_W   = 3;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_DIV1 = 3'd1,
    PS_DIV2 = 3'd2,
    PS_DIV4 = 3'd3,
    PS_DIV8 = 3'd4
  } ps_sel_e;
endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg #(
  parameter int unsigned CNT_W   = refdiv_pkg::RDIV_W,
  parameter int unsigned RESET_R = 5,
  parameter int unsigned MIN_R   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] rdiv,
  input  logic             fr_en,
  input  logic [2:0]       refsel,
  output logic [CNT_W-1:0] r_act,
  output logic             fr_en_q,
  output logic [2:0]       sel_q,
  output logic             clamped
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_R);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_R);

  logic bad;
  assign bad = (rdiv != '0) ? (rdiv != CNT_W'(1) && rdiv < MIN_V) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_act   <= RST_V;
      fr_en_q <= 1'b0;
      sel_q   <= refdiv_pkg::PS_DIV8;
      clamped <= 1'b0;
    end else if (wr) begin
      r_act   <= bad ? MIN_V : rdiv;
      fr_en_q <= fr_en;
      sel_q   <= refsel;
      clamped <= bad;
    end
  end

  // R4: stored ratio is always 1 or at least the minimum
  p_legal_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_act == CNT_W'(1)) || (r_act >= MIN_V));
  // R4: flag set only by a write
  p_flag_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamped) |-> $past(wr));
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int unsigned CNT_W   = refdiv_pkg::RDIV_W,
  parameter int unsigned RESET_R = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] r_act,
  input  logic             fr_en,
  output logic             ref_pulse,
  output logic             fr_out
);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_R);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= RST_V;
      ref_pulse <= 1'b0;
      fr_out    <= 1'b0;
    end else begin
      ref_pulse <= tick & wrap;
      fr_out    <= tick & wrap & fr_en;
      if (tick) cnt <= wrap ? r_act : cnt - CNT_W'(1);
    end
  end

  // R1: no strobe, no movement
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R1: one step down per strobe away from the wrap point
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt > CNT_W'(1)) |=> cnt == $past(cnt) - CNT_W'(1));
  // R5: reload always takes the stored ratio
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt <= CNT_W'(1)) |=> cnt == $past(r_act));
  // R2: a reference pulse is always caused by a strobe
  p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(tick));
  // R6: monitor low while disabled
  p_fr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_en |=> !fr_out);
endmodule

// File: rtl/refdiv_prescale.sv
module refdiv_prescale #(
  parameter int unsigned PS_W = refdiv_pkg::PS_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] sel,
  output logic       refout_pulse
);
  import refdiv_pkg::*;

  logic [PS_W-1:0] pc;
  logic [PS_W:0]   tap;

  assign tap[0] = 1'b1;
  for (genvar k = 1; k <= PS_W; k++) begin : g_tap
    assign tap[k] = &pc[k-1:0];
  end

  logic hit;
  always_comb begin
    unique case (sel)
      PS_DIV1: hit = tap[0];
      PS_DIV2: hit = tap[1];
      PS_DIV4: hit = tap[2];
      PS_DIV8: hit = tap[3];
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc           <= '0;
      refout_pulse <= 1'b0;
    end else begin
      refout_pulse <= tick & hit;
      if (tick) pc <= pc + PS_W'(1);
    end
  end

  // R8: disabled selections keep the output low
  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel inside {PS_DIV1, PS_DIV2, PS_DIV4, PS_DIV8}) |=> !refout_pulse);
  // R7: a prescaled pulse always follows a strobe
  p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refout_pulse |-> $past(tick));
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider #(
  parameter int unsigned CNT_W   = refdiv_pkg::RDIV_W,
  parameter int unsigned RESET_R = 5,
  parameter int unsigned MIN_R   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_rdiv,
  input  logic             cfg_fr_en,
  input  logic [2:0]       cfg_refsel,
  output logic             ref_pulse,
  output logic             fr_out,
  output logic             refout_pulse,
  output logic             rdiv_clamped
);
  logic [CNT_W-1:0] r_act;
  logic             fr_en_q;
  logic [2:0]       sel_q;

  refdiv_cfg #(.CNT_W(CNT_W), .RESET_R(RESET_R), .MIN_R(MIN_R)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .rdiv(cfg_rdiv),
    .fr_en(cfg_fr_en), .refsel(cfg_refsel),
    .r_act(r_act), .fr_en_q(fr_en_q), .sel_q(sel_q), .clamped(rdiv_clamped)
  );

  refdiv_counter #(.CNT_W(CNT_W), .RESET_R(RESET_R)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .r_act(r_act),
    .fr_en(fr_en_q), .ref_pulse(ref_pulse), .fr_out(fr_out)
  );

  refdiv_prescale #(.PS_W(refdiv_pkg::PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .sel(sel_q),
    .refout_pulse(refout_pulse)
  );

  // R6: enabled monitor matches the reference pulse
  p_fr_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fr_out |-> ref_pulse);
endmodule

// File: tb/refclk_divider_bench.sv
module refclk_divider_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        osc_tick = 0;
  logic        cfg_wr = 0;
  logic [14:0] cfg_rdiv = '0;
  logic        cfg_fr_en = 0;
  logic [2:0]  cfg_refsel = '0;
  logic        ref_pulse, fr_out, refout_pulse, rdiv_clamped;

  refclk_divider u_refclk_divider (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cfg_wr(cfg_wr),
    .cfg_rdiv(cfg_rdiv), .cfg_fr_en(cfg_fr_en), .cfg_refsel(cfg_refsel),
    .ref_pulse(ref_pulse), .fr_out(fr_out), .refout_pulse(refout_pulse),
    .rdiv_clamped(rdiv_clamped)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    bit    rp, fr, ro, fl;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nchk = 0;
  int   nfail = 0;
  bit   done = 0;

  // model state
  int m_cnt = 5, m_r = 5, m_pc = 0, m_sel = 4;
  bit m_fe = 0, m_fl = 0;

  function automatic bit ps_hit(int sel, int pc);
    case (sel)
      1: return 1;
      2: return (pc % 2) == 1;
      3: return (pc % 4) == 3;
      4: return (pc % 8) == 7;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: compares items targeted at this cycle
  always @(posedge clk) begin
    cyc++;
    #2;
    while (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "ref_pulse", ref_pulse, e.rp);
      chk(e.tag, "fr_out", fr_out, e.fr);
      chk(e.tag, "refout_pulse", refout_pulse, e.ro);
      chk(e.tag, "rdiv_clamped", rdiv_clamped, e.fl);
    end
  end

  // driver: one clock of stimulus, pushes expected values for after the edge
  task automatic step(bit tk, bit wr, int rv, bit fe, int sel, string tag);
    exp_t e;
    bit wrap;
    @(posedge clk); #1;
    osc_tick = tk; cfg_wr = wr; cfg_rdiv = 15'(rv);
    cfg_fr_en = fe; cfg_refsel = 3'(sel);
    wrap = (m_cnt == 1);
    e.cyc = cyc + 1;
    e.tag = tag;
    e.rp  = tk && wrap;
    e.fr  = tk && wrap && m_fe;
    e.ro  = tk && ps_hit(m_sel, m_pc);
    if (tk) begin
      m_cnt = wrap ? m_r : m_cnt - 1;
      m_pc  = (m_pc + 1) % 8;
    end
    if (wr) begin
      if (rv == 0 || (rv >= 2 && rv <= 4)) begin m_r = 5; m_fl = 1; end
      else begin m_r = rv; m_fl = 0; end
      m_fe = fe; m_sel = sel;
    end
    e.fl = m_fl;
    q.push_back(e);
  endtask

  task automatic run(int n, int gap, string tag);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 0, 0, tag);
      for (int g = 0; g < gap; g++) step(0, 0, 0, 0, 0, tag);
    end
  endtask

  task automatic wcfg(int rv, bit fe, int sel, string tag);
    step(0, 1, rv, fe, sel, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9", "ref_pulse", ref_pulse, 0);
    chk("R9", "fr_out", fr_out, 0);
    chk("R9", "refout_pulse", refout_pulse, 0);
    chk("R9", "rdiv_clamped", rdiv_clamped, 0);
    rst_n = 1;
    run(24, 0, "R2");             // default ratio 5, refout /8 (R7)
    run(15, 2, "R1");             // gapped strobes
    wcfg(5, 1, 4, "R6");
    run(12, 0, "R6");             // monitor enabled
    step(1, 0, 0, 0, 0, "R5");
    wcfg(1, 1, 4, "R5");          // bypass requested mid-period
    run(14, 0, "R3");
    wcfg(3, 1, 4, "R4");
    run(12, 1, "R4");
    wcfg(0, 1, 4, "R4");
    run(6, 0, "R4");
    wcfg(2, 1, 4, "R4");
    wcfg(4, 1, 4, "R4");
    wcfg(6, 1, 4, "R4");          // legal clears flag
    run(13, 0, "R4");
    run(3, 0, "R5");
    wcfg(9, 1, 4, "R5");          // change mid-period
    run(24, 1, "R5");
    for (int s = 0; s < 8; s++) begin
      wcfg(7, 1, s, (s == 0 || s > 4) ? "R8" : "R7");
      run(17, 0, (s == 0 || s > 4) ? "R8" : "R7");
    end
    wcfg(7, 0, 2, "R6");
    run(20, 0, "R6");             // monitor disabled again
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule